// File: doc/BRIEF.md
# Sample Rate Ratio Detector and Anti-Alias Filter Selector

This block estimates how fast input audio samples arrive relative to output samples. It runs on the output system clock, which is 512 times the output sample rate. It receives two single-cycle pulses: one for each synchronised input word-clock edge and one for each output word. Over a window of a fixed number of output words it counts the input edges. The count it holds at the end of a window is the window length times the input-to-output rate ratio, so a larger count means a lower output/input ratio.

At each window end the count is published as the ratio estimate. The count is also compared against five precomputed boundaries, and these boundaries choose one of six anti-aliasing filter modes. The boundaries sit at window length times 33/32, 37/32, 45/32, 51/32 and 65/32. In output/input terms these are the ratios 0.969697, 0.864865, 0.711111, 0.627451 and 0.492308. A lock flag shows that at least one complete window has been measured since reset.

After any break in the input or output clocks the block must be reset, because a count taken across a discontinuous clock is wrong. Measurement then restarts from an empty window. With the default window of 16384 words, the estimate reaches 16-bit resolution one window after reset.

Top module: `ratio_detector`

## Requirements
- R1: A window is 2^WIN_LOG2 output strobes long. In the cycle after the strobe that completes a window, `ratio_o` holds the number of input edge pulses seen in that window, including a pulse in the closing cycle. The edge count then restarts from zero.
- R2: With W = 2^WIN_LOG2 and window count C, `mode_o` is 3'd1 (up-conversion) when C <= W*33/32. A count exactly on this boundary therefore selects mode 1.
- R3: `mode_o` is 3'd2 when W*33/32 < C <= W*37/32. It is 3'd3 when W*37/32 < C <= W*45/32.
- R4: `mode_o` is 3'd4 when W*45/32 < C <= W*51/32. It is 3'd5 when W*51/32 < C <= W*65/32. It is 3'd6 when C > W*65/32.
- R5: `locked_o` is 0 after reset. It goes to 1 in the cycle after the first window ends and stays at 1 until the next reset.
- R6: `mode_o` and `ratio_o` change only in the cycle after a window end, so they are steady within a window. Before the first window ends, `mode_o` is 3'd1 and `ratio_o` is 0.
- R7: The edge count saturates at 2^CNT_W-1 and does not wrap. A saturated window reports that maximum value and selects mode 3'd6.
- R8: An active-low `rst_n` clears `locked_o` to 0, `ratio_o` to 0 and `mode_o` to 3'd1. It also discards the partially counted window, so the next window counts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output system clock (512x output sample rate) |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_edge | input | 1 | One-cycle pulse per synchronised input word-clock edge |
| out_strobe | input | 1 | One-cycle pulse per output word |
| ratio_o | output | CNT_W | Input edges counted in the last complete window |
| mode_o | output | 3 | Selected filter mode, 1 to 6 |
| locked_o | output | 1 | At least one complete window measured since reset |

## Verification
The bench builds the block with WIN_LOG2 = 6 and CNT_W = 8. This gives a 64-word window in which the mode boundaries fall at counts 66, 74, 90, 102 and 130, and the counter saturates at 255. With these values, every boundary can be tested on both sides, and so can saturation, within a few hundred cycles per window. A mid-window reset checks that the partly counted edges are discarded.

// File: rtl/ratio_detector.sv
module ratio_detector #(
  parameter int WIN_LOG2 = 14,
  parameter int CNT_W    = WIN_LOG2 + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_edge,
  input  logic             out_strobe,
  output logic [CNT_W-1:0] ratio_o,
  output logic [2:0]       mode_o,
  output logic             locked_o
);

  localparam int SH = WIN_LOG2 - 5;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [31:0] B1 = 32'(33) << SH;
  localparam logic [31:0] B2 = 32'(37) << SH;
  localparam logic [31:0] B3 = 32'(45) << SH;
  localparam logic [31:0] B4 = 32'(51) << SH;
  localparam logic [31:0] B5 = 32'(65) << SH;

  logic [WIN_LOG2-1:0] word_q;
  logic [CNT_W-1:0]    edge_q, edge_nxt;
  logic                win_end;

  function automatic logic [2:0] pick_mode(input logic [CNT_W-1:0] c);
    logic [31:0] v;
    v = 32'(c);
    if (v <= B1)      return 3'd1;
    else if (v <= B2) return 3'd2;
    else if (v <= B3) return 3'd3;
    else if (v <= B4) return 3'd4;
    else if (v <= B5) return 3'd5;
    else              return 3'd6;
  endfunction

  assign win_end  = out_strobe && (word_q == '1);
  assign edge_nxt = (in_edge && edge_q != CNT_MAX) ? edge_q + 1'b1 : edge_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q   <= '0;
      edge_q   <= '0;
      ratio_o  <= '0;
      mode_o   <= 3'd1;
      locked_o <= 1'b0;
    end else begin
      if (out_strobe) word_q <= word_q + 1'b1;
      if (win_end) begin
        edge_q   <= '0;
        ratio_o  <= edge_nxt;
        mode_o   <= pick_mode(edge_nxt);
        locked_o <= 1'b1;
      end else begin
        edge_q <= edge_nxt;
      end
    end
  end

  assert_window_lock_R1: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |=> locked_o);

  assert_up_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_o && 32'(ratio_o) <= B1) |-> mode_o == 3'd1);

  assert_top_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_o && 32'(ratio_o) > B5) |-> mode_o == 3'd6);

  assert_lock_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    locked_o |=> locked_o);

  assert_hold_in_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !win_end |=> ($stable(mode_o) && $stable(ratio_o)));

  assert_default_before_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !locked_o |-> (mode_o == 3'd1 && ratio_o == '0));

  assert_no_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_q == CNT_MAX && !win_end) |=> edge_q == CNT_MAX);

endmodule

// File: tb/ratio_detector_test.sv
module ratio_detector_test;
  localparam int WL = 6;
  localparam int CW = 8;
  localparam int W  = 1 << WL;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_edge = 1'b0;
  logic out_strobe = 1'b0;
  logic [CW-1:0] ratio_o;
  logic [2:0] mode_o;
  logic locked_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int exp_mode = 1;
  int exp_ratio = 0;

  always #4 clk = ~clk;

  ratio_detector #(.WIN_LOG2(WL), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .in_edge(in_edge), .out_strobe(out_strobe),
    .ratio_o(ratio_o), .mode_o(mode_o), .locked_o(locked_o));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int model_mode(input int c);
    if (c <= W*33/32) return 1;
    if (c <= W*37/32) return 2;
    if (c <= W*45/32) return 3;
    if (c <= W*51/32) return 4;
    if (c <= W*65/32) return 5;
    return 6;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_edge = 1'b0; out_strobe = 1'b0;
    repeat (2) @(negedge clk);
    chk("R8 ratio after reset", int'(ratio_o), 0);
    chk("R8 mode after reset", int'(mode_o), 1);
    chk("R5 locked after reset", int'(locked_o), 0);
    rst_n = 1'b1;
    exp_mode = 1; exp_ratio = 0;
  endtask

  task automatic run_window(input int n, input string req);
    for (int i = 0; i < 8*W; i++) begin
      @(negedge clk);
      if (i == 4*W) begin
        chk({req, " R6 mode held mid-window"}, int'(mode_o), exp_mode);
        chk({req, " R6 ratio held mid-window"}, int'(ratio_o), exp_ratio);
      end
      in_edge = (i < n);
      out_strobe = (i % 8 == 7);
    end
    @(negedge clk);
    in_edge = 1'b0; out_strobe = 1'b0;
    exp_ratio = (n > (1 << CW) - 1) ? (1 << CW) - 1 : n;
    exp_mode = model_mode(exp_ratio);
    chk({req, " R1 ratio"}, int'(ratio_o), exp_ratio);
    chk({req, " mode"}, int'(mode_o), exp_mode);
    chk({req, " R5 locked"}, int'(locked_o), 1);
  endtask

  task automatic first_window();
    for (int i = 0; i < 8*W; i++) begin
      @(negedge clk);
      if (i == 8*W - 1) begin
        chk("R5 not locked before window end", int'(locked_o), 0);
        chk("R6 default mode before lock", int'(mode_o), 1);
      end
      in_edge = (i < W*33/32);
      out_strobe = (i % 8 == 7);
    end
    @(negedge clk);
    in_edge = 1'b0; out_strobe = 1'b0;
    chk("R2 boundary 66 ratio", int'(ratio_o), W*33/32);
    chk("R2 boundary 66 mode", int'(mode_o), 1);
    chk("R5 locked after first window", int'(locked_o), 1);
    exp_ratio = W*33/32; exp_mode = 1;
  endtask

  task automatic reset_mid_window();
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      in_edge = 1'b1;
      out_strobe = (i % 8 == 7);
    end
    do_reset();
    run_window(50, "R8 fresh window after reset");
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    first_window();
    run_window(40,  "R2 up-conversion");
    run_window(67,  "R3 just above 66");
    run_window(74,  "R3 boundary 74");
    run_window(75,  "R3 just above 74");
    run_window(90,  "R3 boundary 90");
    run_window(91,  "R4 just above 90");
    run_window(102, "R4 boundary 102");
    run_window(103, "R4 just above 102");
    run_window(130, "R4 boundary 130");
    run_window(131, "R4 just above 130");
    run_window(400, "R7 saturation");
    run_window(66,  "R2 back to mode 1");
    reset_mid_window();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule